// File: doc/BRIEF.md
# Startup Current Source Sequencer

This block is the digital sequencer for a high-voltage startup current source that has two strengths. It reads four comparator flags: supply above an inhibit level, supply above a turn-on level, supply below a minimum level, and die over-temperature. From these it selects the weak or the strong startup current, turns the source off once the supply can sustain operation, and grants drive switching.

The sequencer has four states: a halted state, a weak-current charge, a strong-current charge, and a running state in which the source is off. A hot die forces the halted state from anywhere. The halted state holds the rest of the controller in reset. The same over-temperature flag also removes drive and both current enables in the cycle it appears, without waiting for a clock edge. When the die cools, a normal startup begins again with the weak current.

Top module: `startup_src_seq`

## Requirements
- R1: While `rst_n` is low the block is in the halted state. The output vector {`low_cur_en`, `high_cur_en`, `logic_rst`, `drv_en`} reads 4'b0010.
- R2: From the halted state with `over_temp` low, the next clock edge enters the weak-current state. The vector then reads 4'b1000.
- R3: In the weak-current state, `above_inhibit` high moves the block to the strong-current state on the next edge. The vector then reads 4'b0100.
- R4: In the strong-current state, `above_inhibit` low with `above_on` low returns the block to the weak-current state on the next edge.
- R5: In the strong-current state, `above_on` high enters the running state on the next edge, whatever the value of `above_inhibit`. The vector then reads 4'b0001.
- R6: In the running state, `below_min` high returns the block to the weak-current state on the next edge.
- R7: `over_temp` high at an edge puts the block in the halted state, whatever the state was. The block stays halted while `over_temp` stays high.
- R8: In any cycle where `over_temp` is high, `drv_en`, `low_cur_en` and `high_cur_en` are low and `logic_rst` is high, in that same cycle.
- R9: Some inputs have no effect in certain states. `above_on` is ignored in the weak-current state, so the strong state is never skipped. `below_min` is ignored in both charging states. `above_inhibit` and `above_on` are ignored in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| above_inhibit | input | 1 | Supply is above the inhibit level |
| above_on | input | 1 | Supply is above the turn-on level |
| below_min | input | 1 | Supply is below the minimum level |
| over_temp | input | 1 | Die over-temperature flag |
| low_cur_en | output | 1 | Enable for the weak startup current |
| high_cur_en | output | 1 | Enable for the strong startup current |
| logic_rst | output | 1 | Reset for the rest of the controller |
| drv_en | output | 1 | Drive switching permitted |

## Verification
The assertions check every state transition on every cycle, including the override into the halted state. They also check that over-temperature clears drive and both current enables in the same cycle it appears. The bench scenarios cover what a single-cycle property does not show well. These are the full walk from power-on to running and back, and the precedence of the turn-on flag over a falling inhibit flag. They also cover the inputs that a state must ignore and holding the halted state across several hot cycles.

// File: rtl/startup_src_seq.sv
module startup_src_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic above_inhibit,
  input  logic above_on,
  input  logic below_min,
  input  logic over_temp,
  output logic low_cur_en,
  output logic high_cur_en,
  output logic logic_rst,
  output logic drv_en
);

  typedef enum logic [1:0] {
    ST_HALT = 2'd0,
    ST_WEAK = 2'd1,
    ST_STRONG = 2'd2,
    ST_RUN = 2'd3
  } seq_state_t;

  seq_state_t st, nxt;

  always_comb begin
    nxt = st;
    if (over_temp) nxt = ST_HALT;
    else begin
      case (st)
        ST_HALT:   nxt = ST_WEAK;
        ST_WEAK:   if (above_inhibit) nxt = ST_STRONG;
        ST_STRONG: if (above_on) nxt = ST_RUN;
                   else if (!above_inhibit) nxt = ST_WEAK;
        ST_RUN:    if (below_min) nxt = ST_WEAK;
        default:   nxt = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_HALT;
    else        st <= nxt;

  assign low_cur_en  = (st == ST_WEAK)   && !over_temp;
  assign high_cur_en = (st == ST_STRONG) && !over_temp;
  assign drv_en      = (st == ST_RUN)    && !over_temp;
  assign logic_rst   = (st == ST_HALT)   || over_temp;

  // R2
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT && !over_temp) |=> (st == ST_WEAK));

  // R3
  weak_to_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WEAK && above_inhibit && !over_temp) |=> high_cur_en || over_temp);

  // R4
  strong_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STRONG && !above_inhibit && !above_on && !over_temp) |=> (st == ST_WEAK));

  // R5
  strong_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STRONG && above_on && !over_temp) |=> (st == ST_RUN));

  // R6
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && below_min && !over_temp) |=> (st == ST_WEAK));

  // R7
  thermal_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |=> (st == ST_HALT) && logic_rst);

  // R8
  thermal_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |-> !drv_en && !low_cur_en && !high_cur_en && logic_rst);

  // R9
  weak_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WEAK) |=> (st != ST_RUN));

endmodule

// File: tb/sim_startup_src_seq.sv
module sim_startup_src_seq;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_inhibit = 1'b0, above_on = 1'b0, below_min = 1'b0, over_temp = 1'b0;
  logic low_cur_en, high_cur_en, logic_rst, drv_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [3:0] V_HALT = 4'b0010, V_WEAK = 4'b1000,
                         V_STRONG = 4'b0100, V_RUN = 4'b0001;

  always #(CLK_P/2) clk = ~clk;

  startup_src_seq u0 (
    .clk(clk), .rst_n(rst_n), .above_inhibit(above_inhibit), .above_on(above_on),
    .below_min(below_min), .over_temp(over_temp), .low_cur_en(low_cur_en),
    .high_cur_en(high_cur_en), .logic_rst(logic_rst), .drv_en(drv_en)
  );

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] act;
    #1;
    act = {low_cur_en, high_cur_en, logic_rst, drv_en};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_in(logic inh, logic on, logic mn, logic ot);
    above_inhibit = inh; above_on = on; below_min = mn; over_temp = ot;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_in(1'b1, 1'b1, 1'b0, 1'b0);
    step(3);
    chk("R1 reset halted", V_HALT);
    set_in(1'b0, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b1;
    step(3);
    chk("R7 held halted while hot", V_HALT);
  endtask

  task automatic t_sequence();
    set_in(1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R2 halted to weak", V_WEAK);
    set_in(1'b0, 1'b1, 1'b1, 1'b0);
    step(2);
    chk("R9 above_on/below_min ignored in weak", V_WEAK);
    set_in(1'b1, 1'b0, 1'b0, 1'b0);
    step();
    chk("R3 weak to strong", V_STRONG);
    set_in(1'b1, 1'b0, 1'b1, 1'b0);
    step(2);
    chk("R9 below_min ignored in strong", V_STRONG);
    set_in(1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R4 strong back to weak", V_WEAK);
    set_in(1'b1, 1'b0, 1'b0, 1'b0);
    step();
    chk("R3 weak to strong again", V_STRONG);
    set_in(1'b0, 1'b1, 1'b0, 1'b0);
    step();
    chk("R5 turn-on wins over inhibit drop", V_RUN);
    set_in(1'b0, 1'b0, 1'b0, 1'b0);
    step(2);
    chk("R9 inhibit/on ignored in run", V_RUN);
    set_in(1'b0, 1'b0, 1'b1, 1'b0);
    step();
    chk("R6 run to weak on low supply", V_WEAK);
  endtask

  task automatic t_thermal(string tag, logic [3:0] pre);
    chk({"R7 precondition ", tag}, pre);
    over_temp = 1'b1;
    chk({"R8 immediate cut ", tag}, V_HALT);
    step();
    chk({"R7 halted after ", tag}, V_HALT);
    step(2);
    chk({"R7 halted stays ", tag}, V_HALT);
    set_in(1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk({"R2 restart after ", tag}, V_WEAK);
  endtask

  task automatic t_thermal_all();
    t_thermal("from weak", V_WEAK);
    set_in(1'b1, 1'b0, 1'b0, 1'b0);
    step();
    t_thermal("from strong", V_STRONG);
    set_in(1'b1, 1'b0, 1'b0, 1'b0);
    step();
    set_in(1'b1, 1'b1, 1'b0, 1'b0);
    step();
    t_thermal("from run", V_RUN);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_thermal_all();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule